// File: doc/BRIEF.md
# Auto-Reload Watchdog Timer with Register Interface

This block is a watchdog-style down-counter that sits on a simple APB-style register bus. Software writes a reload value, turns the counter core on through a run-enable bit, and turns the timer on through a control register. While it runs, the counter steps down by one on every clock. When it reaches zero it reloads itself from the reload value and latches a timeout flag. The flag does not reset the system. It drives a maskable interrupt line that stays high until software clears the flag.

Software can read the live count at any time. While the timer is off, the counter keeps copying the reload value, so a newly written reload value shows up in the count on the next cycle. The interrupt path has four registers: a mask, the raw flag, the masked flag, and a write-one-to-clear register. The run-enable bit is a synchronous enable and not a gated clock. When it is low, the count holds and no timeout can occur. Every bus access takes one transfer with no wait states.

Top module: `wdog_apb`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and the core is stopped, so the count stays at zero even after the timer is switched on.
- R2: While the run-enable bit (offset 0xFF10, bit 0) is 1 and the timer is enabled, the count drops by exactly one per clock cycle.
- R3: When the count is zero while running and enabled, the next cycle reloads it from the reload register (offset 0x0004) and sets the raw timeout flag (bit 0). With reload value L, the flag rises L+1 cycles after the enabling write.
- R4: While the timer is disabled and the core runs, the count takes the reload register value on every cycle.
- R5: Writing 1 to bit 0 of the control register (offset 0x0008) enables the timer, and writing 0 disables it.
- R6: The masked status register (0xFF04) reads raw status (0xFF08) ANDed with the mask (0xFF00), and `irq` is high exactly when a masked bit is set.
- R7: Writing a 1 in bit 0 of the clear register (0xFF0C) clears the raw flag and, with it, the masked flag and `irq`. Writing 0 there, or writing anything to the masked status register, leaves the flag unchanged.
- R8: A timeout in the same cycle as a clear leaves the raw flag set.
- R9: While the run-enable bit is 0, the count holds its value and no timeout occurs.
- R10: The count register (0x0000) is read-only, and unmapped offsets read zero.
- R11: A reload value of zero makes the counter expire on every cycle while enabled, so the count reads zero and the flag stays set.
- R12: `pready` is always high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 16 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete, tied high |
| irq | output | 1 | Timeout interrupt (OR of masked flags) |

## Verification
On every cycle, the bound checker confirms that the count steps down by one, reloads and flags on expiry, follows the reload value while disabled, and freezes when the core is stopped. It also confirms that a clear with no coinciding timeout drops the flag, that `irq` never shows without the raw flag, and that `pready` stays high. The directed scenarios cover what needs software-visible sequences. These include the exact L+1 cycle delay to the first interrupt, the read-back of mask and masked status, clears that have no effect, the set-wins race under a zero reload value, and the zero reads from unmapped or read-only offsets.

// File: rtl/wdog_apb.sv
module wdog_apb #(
  parameter int W  = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [W-1:0]  pwdata,
  output logic [W-1:0]  prdata,
  output logic          pready,
  output logic          irq
);
  localparam logic [AW-1:0] OFS_COUNT = AW'('h0000);
  localparam logic [AW-1:0] OFS_RELD  = AW'('h0004);
  localparam logic [AW-1:0] OFS_CTRL  = AW'('h0008);
  localparam logic [AW-1:0] OFS_MASK  = AW'('hFF00);
  localparam logic [AW-1:0] OFS_MSTAT = AW'('hFF04);
  localparam logic [AW-1:0] OFS_RSTAT = AW'('hFF08);
  localparam logic [AW-1:0] OFS_CLR   = AW'('hFF0C);
  localparam logic [AW-1:0] OFS_RUN   = AW'('hFF10);

  logic [W-1:0] count, reld;
  logic         tmr_on, core_on, mask, raw;
  logic         wr, expire;

  assign wr     = psel & penable & pwrite;
  assign expire = core_on & tmr_on & (count == '0);
  assign pready = 1'b1;
  assign irq    = raw & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reld    <= '0;
      tmr_on  <= 1'b0;
      mask    <= 1'b0;
      core_on <= 1'b0;
    end else if (wr) begin
      case (paddr)
        OFS_RELD: reld    <= pwdata;
        OFS_CTRL: tmr_on  <= pwdata[0];
        OFS_MASK: mask    <= pwdata[0];
        OFS_RUN:  core_on <= pwdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (core_on) begin
      if (!tmr_on || count == '0)
        count <= reld;
      else
        count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      raw <= 1'b0;
    else if (expire)
      raw <= 1'b1;
    else if (wr && paddr == OFS_CLR && pwdata[0])
      raw <= 1'b0;
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      OFS_COUNT: prdata = count;
      OFS_RELD:  prdata = reld;
      OFS_CTRL:  prdata[0] = tmr_on;
      OFS_MASK:  prdata[0] = mask;
      OFS_MSTAT: prdata[0] = raw & mask;
      OFS_RSTAT: prdata[0] = raw;
      OFS_RUN:   prdata[0] = core_on;
      default:   prdata = '0;
    endcase
  end
endmodule

module wdog_apb_chk #(
  parameter int W  = 32,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [W-1:0]  pwdata,
  input logic          pready,
  input logic          irq,
  input logic [W-1:0]  count,
  input logic [W-1:0]  reld,
  input logic          tmr_on,
  input logic          core_on,
  input logic          raw
);
  logic clr_hit, due;
  assign clr_hit = psel && penable && pwrite && paddr == AW'('hFF0C) && pwdata[0];
  assign due     = core_on && tmr_on && count == '0;

  // R2
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_on && tmr_on && count != '0) |=> count == $past(count) - 1'b1);
  // R3
  reload_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    due |=> (raw && count == $past(reld)));
  // R4
  follow_reld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_on && !tmr_on) |=> count == $past(reld));
  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_on |=> $stable(count));
  // R7
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !due) |=> !raw);
  // R6
  irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |-> !irq);
  // R12
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pready);
endmodule

bind wdog_apb wdog_apb_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pready(pready), .irq(irq),
  .count(count), .reld(reld), .tmr_on(tmr_on), .core_on(core_on), .raw(raw)
);

// File: tb/wdog_apb_test.sv
`timescale 1ns/1ps
module wdog_apb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  wdog_apb uut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk) penable = 1;
    @(negedge clk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk) penable = 1;
    d = prdata;
    @(negedge clk) begin psel = 0; penable = 0; end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", irq, 0);
    chk("R12 pready", pready, 1);
    rd(16'h0000, v); chk("R1 count", v, 0);
    rd(16'hFF08, v); chk("R1 raw", v, 0);
    rd(16'hFF10, v); chk("R1 run", v, 0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(16'h0004, 50);
    wr(16'h0008, 1);
    repeat (10) @(negedge clk);
    rd(16'h0000, v); chk("R1 R9 stopped count", v, 0);
    rd(16'hFF08, v); chk("R9 no timeout", v, 0);
    wr(16'h0008, 0);
    wr(16'hFF10, 1);
    rd(16'h0000, v); chk("R4 R5 follows reload", v, 50);
    wr(16'h0004, 77);
    rd(16'h0000, v); chk("R4 new reload", v, 77);
  endtask

  task automatic t_count();
    logic [31:0] a, b;
    wr(16'h0004, 1000);
    wr(16'h0008, 1);
    rd(16'h0000, a); chk("R2 first step", a, 999);
    rd(16'h0000, b); chk("R2 rate", b, 997);
    wr(16'hFF10, 0);
    rd(16'h0000, a);
    repeat (5) @(negedge clk);
    rd(16'h0000, b); chk("R9 frozen", b, a);
    wr(16'hFF10, 1);
    wr(16'h0008, 0);
    rd(16'h0000, a); chk("R5 disable", a, 1000);
  endtask

  task automatic t_expiry();
    logic [31:0] v;
    int k;
    wr(16'hFF0C, 1);
    wr(16'hFF00, 1);
    wr(16'h0004, 5);
    chk("R6 irq idle", irq, 0);
    wr(16'h0008, 1);
    k = 0;
    for (int i = 1; i <= 50; i++) begin
      @(negedge clk);
      if (irq && k == 0) k = i;
    end
    chk("R3 delay L+1", k, 6);
    wr(16'h0008, 0);
    rd(16'hFF08, v); chk("R3 raw set", v, 1);
    wr(16'hFF00, 0);
    chk("R6 masked irq", irq, 0);
    rd(16'hFF04, v); chk("R6 masked status off", v, 0);
    wr(16'hFF00, 1);
    rd(16'hFF04, v); chk("R6 masked status on", v, 1);
    chk("R6 irq on", irq, 1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(16'hFF04, 0);
    rd(16'hFF08, v); chk("R7 mis write ignored", v, 1);
    wr(16'hFF0C, 0);
    rd(16'hFF08, v); chk("R7 clear zero ignored", v, 1);
    wr(16'hFF0C, 1);
    rd(16'hFF08, v); chk("R7 cleared raw", v, 0);
    rd(16'hFF04, v); chk("R7 cleared masked", v, 0);
    chk("R7 irq low", irq, 0);
  endtask

  task automatic t_zero_load();
    logic [31:0] v;
    wr(16'h0004, 0);
    wr(16'h0008, 1);
    repeat (3) @(negedge clk);
    rd(16'hFF08, v); chk("R11 flag", v, 1);
    wr(16'hFF0C, 1);
    rd(16'hFF08, v); chk("R8 set wins", v, 1);
    rd(16'h0000, v); chk("R11 count zero", v, 0);
    wr(16'h0008, 0);
    wr(16'hFF0C, 1);
    rd(16'hFF08, v); chk("R7 final clear", v, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(16'h0000, 123);
    rd(16'h0000, v); chk("R10 count read-only", v, 0);
    rd(16'h0010, v); chk("R10 unmapped low", v, 0);
    rd(16'hFF14, v); chk("R10 unmapped high", v, 0);
    chk("R12 pready", pready, 1);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_count();
    t_expiry();
    t_clear();
    t_zero_load();
    t_map();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule